// File: doc/BRIEF.md
# Serial-to-Parallel Character Display Latch

This block is the receiving end of a four-wire serial link that drives a character display module. A controller shifts 16-bit words in on a data line, clocked by a serial clock, while it holds an active-low select line low. The block assembles each word and, when the select line returns high, copies it onto a parallel bus: eight display data lines plus the register-select, read/write and enable strobes. The display therefore never sees a partially shifted word. To pulse the display enable strobe, the controller sends the same word two or three times and changes only the enable bit.

The serial clock, the select line and the serial data are brought into the system clock domain through two-flop synchronisers. All edges are detected in that domain. The serial clock must therefore run well below the system clock: each of its phases must last at least three system clock cycles. A frame is accepted only if exactly 16 serial clock rising edges were seen while the block was selected. A shorter or longer frame is discarded, and the parallel outputs keep their previous values.

Top module: `lcd_link_rx`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted frame, db_o, rs_o, rw_o and en_o are all 0.
- R2: Data is sampled on rising serial clock edges with the most significant bit first. Frame bits 7..0 appear on db_o[7:0].
- R3: Frame bit 8 drives en_o, bit 9 drives rw_o (1 = read from the display, 0 = write) and bit 10 drives rs_o (1 = character data, 0 = instruction).
- R4: The parallel outputs change only in response to a rising edge of sel_ni. They hold their values while a frame is being shifted in.
- R5: A new value appears on the outputs at the third rising clk_i edge after sel_ni rises, and not before.
- R6: Serial clock edges that occur while sel_ni is high have no effect on the outputs and are not counted toward the next frame.
- R7: A frame with fewer than 16 bits is discarded, and the outputs keep their previous values.
- R8: A frame with more than 16 bits is discarded, and the outputs keep their previous values.
- R9: Frame bits 15..11 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock, asynchronous, idle low |
| sel_ni | input | 1 | Select, active low, asynchronous |
| mosi_i | input | 1 | Serial data, most significant bit first |
| db_o | output | 8 | Display data bus |
| rs_o | output | 1 | Register select: 1 = data, 0 = instruction |
| rw_o | output | 1 | Read/write: 1 = read, 0 = write |
| en_o | output | 1 | Display enable strobe level |

## Verification
The only timed result is the output update. It is due at the third rising clk_i edge after sel_ni rises: two synchroniser stages, then the edge-detect flop feeding the output register. The driver changes inputs on falling clk_i edges. For every frame it queues the previous and the new expected bus value and flags the select rise. The monitor then samples at the second falling edge after the rise, where the old value must still be present, and at the third, where the new value (or, for a rejected frame, the unchanged value) must be present. Serial clock phases of four system cycles keep the synchronised data stable around each sampled edge.

// File: rtl/lcd_link_pkg.sv
package lcd_link_pkg;
  localparam int EN_POS = 8;
  localparam int RW_POS = 9;
  localparam int RS_POS = 10;

  typedef struct packed {
    logic       rs;
    logic       rw;
    logic       en;
    logic [7:0] db;
  } lcd_bus_t;
endpackage

// File: rtl/lcd_link_sync.sv
module lcd_link_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  // STAGES synchroniser flops plus one history flop for edge detection
  localparam int DEPTH = STAGES + 1;

  logic [WIDTH-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~stg_q[STAGES];
  assign fall_o = ~stg_q[STAGES-1] & stg_q[STAGES];
endmodule

// File: rtl/lcd_link_shift.sv
module lcd_link_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_lvl_i,   // synchronised, active low
  input  logic               sck_rise_i,
  input  logic               mosi_i,
  output logic [FRAME_W-1:0] word_o,
  output logic               full_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               take_bit;

  assign take_bit = sck_rise_i && !sel_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
    end else if (take_bit) begin
      shreg_q <= {shreg_q[FRAME_W-2:0], mosi_i};
    end
  end

  // Saturating count: CNT_OVER marks an overlong frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (sel_lvl_i) begin
      cnt_q <= '0;
    end else if (take_bit && cnt_q != CNT_OVER) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o = shreg_q;
  assign full_o = (cnt_q == CNT_FULL);

  // R2
  new_bit_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_bit |=> shreg_q[0] == $past(mosi_i));
  // R6
  idle_cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_lvl_i |=> cnt_q == '0);
  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_OVER);
endmodule

// File: rtl/lcd_link_latch.sv
module lcd_link_latch
  import lcd_link_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  output lcd_bus_t           bus_o
);
  lcd_bus_t bus_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q <= '0;
    end else if (load_i) begin
      bus_q.db <= word_i[7:0];
      bus_q.en <= word_i[EN_POS];
      bus_q.rw <= word_i[RW_POS];
      bus_q.rs <= word_i[RS_POS];
    end
  end

  assign bus_o = bus_q;
endmodule

// File: rtl/lcd_link_rx.sv
module lcd_link_rx
  import lcd_link_pkg::*;
#(
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       sel_ni,
  input  logic       mosi_i,
  output logic [7:0] db_o,
  output logic       rs_o,
  output logic       rw_o,
  output logic       en_o
);
  // bit order in the synchroniser: {mosi, sel, sck}; sel idles high
  localparam int SYNC_W = 3;
  localparam logic [SYNC_W-1:0] SYNC_RST = 3'b010;

  logic [SYNC_W-1:0] lvl, rise, fall;
  logic [FRAME_W-1:0] word;
  logic               full;
  logic               sel_rise;
  logic               load;
  lcd_bus_t           bus;

  lcd_link_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({mosi_i, sel_ni, sck_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  lcd_link_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_lvl_i (lvl[1]),
    .sck_rise_i(rise[0]),
    .mosi_i    (lvl[2]),
    .word_o    (word),
    .full_o    (full)
  );

  assign sel_rise = rise[1];
  assign load     = sel_rise && full;

  lcd_link_latch #(.FRAME_W(FRAME_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .word_i(word),
    .bus_o (bus)
  );

  assign db_o = bus.db;
  assign rs_o = bus.rs;
  assign rw_o = bus.rw;
  assign en_o = bus.en;

  // R4
  hold_without_sel_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_rise |=> $stable({rs_o, rw_o, en_o, db_o}));
  // R7
  bad_len_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_rise && !full) |=> $stable({rs_o, rw_o, en_o, db_o}));
  // R3
  ctrl_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_rise && full) |=> (en_o == $past(word[EN_POS])) && (rs_o == $past(word[RS_POS]))
                           && (rw_o == $past(word[RW_POS])));
  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> {rs_o, rw_o, en_o, db_o} == '0);

  logic unused_fall;
  assign unused_fall = ^fall;
endmodule

// File: tb/lcd_link_rx_tb_top.sv
module lcd_link_rx_tb_top;
  localparam int HALF  = 4;       // serial clock half period in clk cycles
  localparam int LIMIT = 20000;

  typedef struct {
    logic [10:0] old_v;
    logic [10:0] new_v;
    string       req;
  } item_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sck_i = 1'b0;
  logic sel_ni = 1'b1;
  logic mosi_i = 1'b0;
  logic [7:0] db_o;
  logic rs_o, rw_o, en_o;

  always #2 clk_i = ~clk_i;

  lcd_link_rx dut_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .sel_ni(sel_ni),
    .mosi_i(mosi_i), .db_o(db_o), .rs_o(rs_o), .rw_o(rw_o), .en_o(en_o)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  item_t sb_q[$];
  logic [10:0] cur_exp = '0;
  event sel_rose;

  wire [10:0] obs = {rs_o, rw_o, en_o, db_o};

  function automatic logic [10:0] to_bus(logic [15:0] w);
    return {w[10], w[9], w[8], w[7:0]};
  endfunction

  task automatic check(string req, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drives a frame of n bits (w[n-1] first) and queues the expected outcome
  task automatic send(logic [31:0] w, int n, string req);
    item_t it;
    @(negedge clk_i);
    sel_ni = 1'b0;
    repeat (HALF) @(negedge clk_i);
    for (int i = n - 1; i >= 0; i--) begin
      mosi_i = w[i];
      repeat (HALF) @(negedge clk_i);
      sck_i = 1'b1;
      repeat (HALF) @(negedge clk_i);
      sck_i = 1'b0;
    end
    repeat (HALF) @(negedge clk_i);
    check("R4 hold while shifting", obs, cur_exp);
    it.old_v = cur_exp;
    if (n == 16) cur_exp = to_bus(w[15:0]);
    it.new_v = cur_exp;
    it.req = req;
    sb_q.push_back(it);
    sel_ni = 1'b1;
    -> sel_rose;
    repeat (6) @(negedge clk_i);
  endtask

  task automatic pulse_idle(int n);
    for (int i = 0; i < n; i++) begin
      mosi_i = 1'b1;
      repeat (HALF) @(negedge clk_i);
      sck_i = 1'b1;
      repeat (HALF) @(negedge clk_i);
      sck_i = 1'b0;
    end
    repeat (6) @(negedge clk_i);
  endtask

  // monitor: old value two edges after the select rise, new value at the third
  initial begin
    item_t it;
    forever begin
      @(sel_rose);
      it = sb_q.pop_front();
      @(negedge clk_i);
      @(negedge clk_i);
      check("R5 not yet updated", obs, it.old_v);
      @(negedge clk_i);
      check(it.req, obs, it.new_v);
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < LIMIT) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 in reset", obs, 11'h000);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1 after release", obs, 11'h000);

    send(32'h05A5, 16, "R2 R3 data frame");
    send(32'hF83C, 16, "R9 upper bits ignored");
    send(32'h0201, 16, "R3 read flag");
    send(32'h0780, 16, "R3 all control bits");
    send(32'h01FF, 9,  "R7 short frame dropped");
    send(32'hABCDE, 20, "R8 long frame dropped");
    pulse_idle(8);
    check("R6 idle clocks no effect", obs, cur_exp);
    send(32'h0455, 16, "R6 frame after idle clocks");
    send(32'h00FF, 16, "R2 msb first");

    repeat (10) @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule